// File: doc/BRIEF.md
# Periodic Light Measurement Scheduler

This block sets the timing of periodic light-measurement conversions for an ambient light sensor. Software writes three small configuration registers through a plain write strobe: a control register (enable and soft reset), a timing register (converter resolution and repeat rate) and a gain register. Once enabled from standby, the block waits through a settling interval and then runs conversions. The resolution sets the length of each conversion and the rate sets how often one starts. When a conversion ends, the block samples the front-end count, clips it to the selected resolution and raises a one-cycle strobe with the result.

Time is counted in units of 3.125 ms. Each unit is `TICK_DIV` clock cycles long, and this parameter lets a bench scale real time down. The block has four states. STANDBY is idle. SETTLE counts `SETTLE_UNITS` units after enable. CONVERT runs one conversion. WAIT holds the remainder of the repeat period. The transitions are as follows. *enable* goes from STANDBY to SETTLE. *settled* goes from SETTLE to CONVERT. *done-wait* goes from CONVERT to WAIT when the period is not yet over. *done-again* goes from CONVERT back to CONVERT when the period is already over, which is the back-to-back fallback. *period* goes from WAIT to CONVERT. *drain* goes from CONVERT to STANDBY when a conversion finishes with enable cleared. *restart* forces CONVERT, or SETTLE when the block was not yet converting. *abort* and *soft reset* force STANDBY.

Top module: `light_meas_sched`

## Requirements
- R1: After reset, and after a control write with bit 4 set, the block is in standby. `gain_sel` reads 1, the resolution code is 010 and the rate code is 010. Enable is cleared.
- R2: A control write with bit 1 set while in standby starts the settle phase. The first conversion then starts after `SETTLE_UNITS` units, so the first `result_vld` comes (SETTLE_UNITS + conversion units) × TICK_DIV cycles after the write edge.
- R3: The timing register holds the resolution in bits 6:4. Codes 0 to 5 give 20, 19, 18, 17, 16 and 13 bits, with conversions of 128, 64, 32, 16, 8 and 1 units. The reserved codes 6 and 7 behave as code 2.
- R4: Timing register bits 2:0 select the repeat period between conversion starts. Codes 0 to 7 give 8, 16, 32, 64, 160, 320, 640 and 640 units.
- R5: When the repeat period is shorter than the conversion, conversions run back to back, so the period equals the conversion length.
- R6: At the end of a conversion, `result` becomes min(`sample_in`, 2^bits − 1), unsigned and LSB-aligned. `result_vld` is high for exactly that one cycle.
- R7: While enabled, a write to the timing or gain register, or a control write with bit 1 set, abandons the conversion in flight without a result. If the block was converting or waiting, a new conversion starts at the write edge; if it was in standby or settling, the settle phase starts again.
- R8: A control write that clears bit 1 lets the running conversion finish and deliver its result, then the block enters standby and produces no more results. A timing or gain write while disabled aborts such a drain.
- R9: The gain register codes 0 to 4 appear on `gain_sel`. A write of codes 5 to 7 leaves `gain_sel` unchanged.
- R10: A write with `cfg_sel` = 3 changes no register and does not disturb the schedule.
- R11: `busy` is high exactly in CONVERT and `standby` exactly in STANDBY. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 control, 1 timing, 2 gain, 3 unused |
| cfg_wdata | input | 8 | Write data |
| sample_in | input | RAW_W | Raw count from the front end |
| gain_sel | output | 3 | Gain code for the front end |
| busy | output | 1 | Conversion in progress |
| standby | output | 1 | Block idle |
| result | output | RES_W | Clipped conversion result |
| result_vld | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that `sample_in` is at least as wide as the result, that `TICK_DIV` and `SETTLE_UNITS` are at least 1, and that writes arrive as single-cycle strobes that are never held across a conversion end. The pulse and clipping properties also rely on the resolution code not changing in the cycle a result appears. That holds because every timing write restarts the schedule and suppresses the pending result. The stimulus drives one write strobe at a time on the falling edge. It holds `sample_in` steady for each measured conversion, and it draws random resolution and rate codes only from the defined ranges, alongside the directed reserved-code and abort cases.

// File: rtl/lms_pkg.sv
package lms_pkg;

    localparam int UNIT_W = 10;

    typedef enum logic [1:0] {
        ST_STANDBY,
        ST_SETTLE,
        ST_CONVERT,
        ST_WAIT
    } sched_state_t;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_TIMING = 2'd1;
    localparam logic [1:0] SEL_GAIN   = 2'd2;

    localparam logic [2:0] RES_DEFAULT  = 3'b010;
    localparam logic [2:0] RATE_DEFAULT = 3'b010;
    localparam logic [2:0] GAIN_DEFAULT = 3'b001;
    localparam logic [2:0] GAIN_MAX     = 3'd4;

    function automatic logic [UNIT_W-1:0] conv_units_f(input logic [2:0] code);
        case (code)
            3'd0:    return UNIT_W'(128);
            3'd1:    return UNIT_W'(64);
            3'd3:    return UNIT_W'(16);
            3'd4:    return UNIT_W'(8);
            3'd5:    return UNIT_W'(1);
            default: return UNIT_W'(32);
        endcase
    endfunction

    function automatic logic [4:0] res_bits_f(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd20;
            3'd1:    return 5'd19;
            3'd3:    return 5'd17;
            3'd4:    return 5'd16;
            3'd5:    return 5'd13;
            default: return 5'd18;
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] rate_units_f(input logic [2:0] code);
        case (code)
            3'd0:    return UNIT_W'(8);
            3'd1:    return UNIT_W'(16);
            3'd2:    return UNIT_W'(32);
            3'd3:    return UNIT_W'(64);
            3'd4:    return UNIT_W'(160);
            3'd5:    return UNIT_W'(320);
            default: return UNIT_W'(640);
        endcase
    endfunction

endpackage

// File: rtl/lms_tick_gen.sv
module lms_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/lms_timing_decode.sv
module lms_timing_decode
    import lms_pkg::*;
#(
    parameter int RES_W = 20
) (
    input  logic [2:0]        res_code,
    input  logic [2:0]        rate_code,
    output logic [UNIT_W-1:0] conv_units,
    output logic [UNIT_W-1:0] rate_units,
    output logic [RES_W-1:0]  limit
);
    logic [4:0]  bits;
    logic [31:0] lim_full;
    logic        unused_hi;

    always_comb begin
        conv_units = conv_units_f(res_code);
        rate_units = rate_units_f(rate_code);
        bits       = res_bits_f(res_code);
        lim_full   = (32'd1 << bits) - 32'd1;
        limit      = lim_full[RES_W-1:0];
    end

    assign unused_hi = ^lim_full[31:RES_W];
endmodule

// File: rtl/light_meas_sched.sv
module light_meas_sched
    import lms_pkg::*;
#(
    parameter int TICK_DIV     = 4,
    parameter int SETTLE_UNITS = 2,
    parameter int RAW_W        = 24,
    parameter int RES_W        = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [RAW_W-1:0] sample_in,
    output logic [2:0]       gain_sel,
    output logic             busy,
    output logic             standby,
    output logic [RES_W-1:0] result,
    output logic             result_vld
);
    localparam logic [UNIT_W-1:0] SETTLE_CNT = UNIT_W'(SETTLE_UNITS);

    sched_state_t      state_q, state_d;
    logic [UNIT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic              en_q;
    logic [2:0]        res_q, rate_q, gain_q;
    logic              fire, tick, tick_clr;
    logic              soft_rst, wr_ctrl, wr_cfg, restart;
    logic [UNIT_W-1:0] conv_units, rate_units;
    logic [RES_W-1:0]  limit;
    logic [RES_W-1:0]  clipped;
    logic              unused_wbits;

    assign unused_wbits = ^{cfg_wdata[7], cfg_wdata[3]};

    assign wr_ctrl  = cfg_we && (cfg_sel == SEL_CTRL);
    assign wr_cfg   = cfg_we && (cfg_sel == SEL_TIMING || cfg_sel == SEL_GAIN);
    assign soft_rst = wr_ctrl && cfg_wdata[4];
    assign restart  = (wr_ctrl && cfg_wdata[1]) || (wr_cfg && en_q);
    assign tick_clr = soft_rst || restart || wr_cfg || (state_q == ST_STANDBY);
    assign cnt_inc  = cnt_q + UNIT_W'(1);

    lms_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    lms_timing_decode #(.RES_W(RES_W)) i_decode (
        .res_code   (res_q),
        .rate_code  (rate_q),
        .conv_units (conv_units),
        .rate_units (rate_units),
        .limit      (limit)
    );

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            res_q  <= RES_DEFAULT;
            rate_q <= RATE_DEFAULT;
            gain_q <= GAIN_DEFAULT;
        end else if (soft_rst) begin
            en_q   <= 1'b0;
            res_q  <= RES_DEFAULT;
            rate_q <= RATE_DEFAULT;
            gain_q <= GAIN_DEFAULT;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL:   en_q <= cfg_wdata[1];
                SEL_TIMING: begin
                    res_q  <= cfg_wdata[6:4];
                    rate_q <= cfg_wdata[2:0];
                end
                SEL_GAIN:   if (cfg_wdata[2:0] <= GAIN_MAX) gain_q <= cfg_wdata[2:0];
                default:    ;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (soft_rst) begin
            state_d = ST_STANDBY;
            cnt_d   = '0;
        end else if (restart) begin
            state_d = (state_q == ST_STANDBY || state_q == ST_SETTLE) ? ST_SETTLE : ST_CONVERT;
            cnt_d   = '0;
        end else if (wr_cfg) begin
            state_d = ST_STANDBY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_STANDBY: ;
                ST_SETTLE: begin
                    if (!en_q) begin
                        state_d = ST_STANDBY;
                        cnt_d   = '0;
                    end else if (tick) begin
                        if (cnt_inc >= SETTLE_CNT) begin
                            state_d = ST_CONVERT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                ST_CONVERT: begin
                    if (tick) begin
                        if (cnt_inc >= conv_units) begin
                            fire = 1'b1;
                            if (!en_q) begin
                                state_d = ST_STANDBY;
                                cnt_d   = '0;
                            end else if (cnt_inc >= rate_units) begin
                                cnt_d = '0;
                            end else begin
                                state_d = ST_WAIT;
                                cnt_d   = cnt_inc;
                            end
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!en_q) begin
                        state_d = ST_STANDBY;
                        cnt_d   = '0;
                    end else if (tick) begin
                        if (cnt_inc >= rate_units) begin
                            state_d = ST_CONVERT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        if (sample_in > RAW_W'(limit))
            clipped = limit;
        else
            clipped = sample_in[RES_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= fire;
            if (fire)
                result <= clipped;
        end
    end

    assign busy     = (state_q == ST_CONVERT);
    assign standby  = (state_q == ST_STANDBY);
    assign gain_sel = gain_q;
endmodule

// File: rtl/light_meas_sched_chk.sv
module light_meas_sched_chk
    import lms_pkg::*;
#(
    parameter int RES_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic [7:0]       cfg_wdata,
    input logic [2:0]       res_q,
    input logic [2:0]       gain_sel,
    input logic             busy,
    input logic             standby,
    input logic [RES_W-1:0] result,
    input logic             result_vld
);
    logic [4:0] bits;
    assign bits = res_bits_f(res_q);

    assert_soft_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_CTRL && cfg_wdata[4]) |=> (standby && gain_sel == GAIN_DEFAULT));

    assert_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> ((result >> bits) == '0));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    assert_abort_no_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_TIMING) |=> !result_vld);

    assert_result_after_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> $past(busy));

    assert_quiet_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> !result_vld);

    assert_gain_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gain_sel <= GAIN_MAX);

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && standby));
endmodule

bind light_meas_sched light_meas_sched_chk #(.RES_W(RES_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .res_q      (res_q),
    .gain_sel   (gain_sel),
    .busy       (busy),
    .standby    (standby),
    .result     (result),
    .result_vld (result_vld)
);

// File: tb/test_light_meas_sched.sv
module test_light_meas_sched;
    localparam int D = 4;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [23:0] sample_in = 24'hFFFFFF;
    logic [2:0]  gain_sel;
    logic        busy, standby, result_vld;
    logic [19:0] result;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    light_meas_sched i_light_meas_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sample_in(sample_in), .gain_sel(gain_sel),
        .busy(busy), .standby(standby), .result(result), .result_vld(result_vld)
    );

    function automatic int f_conv(input int r);
        case (r)
            0: return 128; 1: return 64; 3: return 16; 4: return 8; 5: return 1;
            default: return 32;
        endcase
    endfunction

    function automatic int f_bits(input int r);
        case (r)
            0: return 20; 1: return 19; 3: return 17; 4: return 16; 5: return 13;
            default: return 18;
        endcase
    endfunction

    function automatic int f_rate(input int r);
        case (r)
            0: return 8; 1: return 16; 2: return 32; 3: return 64;
            4: return 160; 5: return 320; default: return 640;
        endcase
    endfunction

    function automatic longint f_clip(input longint s, input int r);
        longint lim = (longint'(1) << f_bits(r)) - 1;
        return (s > lim) ? lim : s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d, output int c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        c = cyc;
    endtask

    task automatic wait_vld(input int limit, output int at, output longint val);
        at = -1; val = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (result_vld) begin
                at = cyc; val = result;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0, c1, t, t2;
        longint v, v2;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(standby == 1'b1 && busy == 1'b0, "R1 standby after reset", {busy, standby}, 2'b01);
        check(gain_sel == 3'd1, "R1 gain default", gain_sel, 1);
        check(result_vld == 1'b0 && result == 20'd0, "R1 no result", result, 0);

        // R2 enable with defaults, R3 18-bit, R6 clip
        wr(2'd0, 8'h02, c0);
        wait_vld(3000, t, v);
        check(t == c0 + (S + 32) * D, "R2 first result latency", t - c0, (S + 32) * D);
        check(v == 64'h3FFFF, "R6 clip at 18 bits", v, 64'h3FFFF);
        check(busy == 1'b1 && standby == 1'b0, "R11 busy during back-to-back", {busy, standby}, 2'b10);

        // R10 unused select has no effect, R4 default period
        wr(2'd3, 8'hFF, c1);
        wait_vld(3000, t2, v2);
        check(t2 == t + 32 * D, "R10 schedule unchanged by unused write", t2 - t, 32 * D);

        // R5 fallback: 20-bit conversion, 8-unit rate
        wr(2'd1, 8'h00, c0);
        wait_vld(3000, t, v);
        check(t == c0 + 128 * D, "R7 restart into conversion", t - c0, 128 * D);
        check(v == 64'hFFFFF, "R6 clip at 20 bits", v, 64'hFFFFF);
        wait_vld(3000, t2, v2);
        check(t2 == t + 128 * D, "R5 back-to-back period", t2 - t, 128 * D);

        // R4 rate slower than conversion
        wr(2'd1, 8'h41, c0);
        wait_vld(3000, t, v);
        check(t == c0 + 8 * D, "R3 16-bit conversion length", t - c0, 8 * D);
        wait_vld(3000, t2, v2);
        check(t2 == t + 16 * D, "R4 16-unit period", t2 - t, 16 * D);

        // R3 13-bit
        wr(2'd1, 8'h50, c0);
        wait_vld(3000, t, v);
        check(t == c0 + 1 * D, "R3 13-bit conversion length", t - c0, D);
        check(v == 64'h1FFF, "R6 clip at 13 bits", v, 64'h1FFF);

        // R7 abort via gain write, R9 gain codes
        sample_in = 24'h000123;
        wr(2'd1, 8'h40, c0);
        idle(18);
        wr(2'd2, 8'h04, c1);
        check(gain_sel == 3'd4, "R9 gain code 4 applied", gain_sel, 4);
        wait_vld(3000, t, v);
        check(t == c1 + 8 * D, "R7 gain write restarts conversion", t - c1, 8 * D);
        check(v == 64'h123, "R6 in-range value passes", v, 64'h123);
        wr(2'd2, 8'h06, c1);
        check(gain_sel == 3'd4, "R9 reserved gain code ignored", gain_sel, 4);

        // R8 disable lets conversion finish
        sample_in = 24'hFFFFFF;
        wr(2'd1, 8'h41, c0);
        idle(8);
        wr(2'd0, 8'h00, c1);
        wait_vld(3000, t, v);
        check(t == c0 + 8 * D, "R8 conversion in flight completes", t - c0, 8 * D);
        check(standby == 1'b1 && busy == 1'b0, "R8 standby after drain", {busy, standby}, 2'b01);
        wait_vld(3000, t2, v2);
        check(t2 == -1, "R8 no results after drain", t2, -1);

        // R1 soft reset restores defaults
        wr(2'd0, 8'h02, c0);
        wr(2'd1, 8'h41, c0);
        wr(2'd2, 8'h03, c0);
        idle(5);
        wr(2'd0, 8'h12, c0);
        check(standby == 1'b1, "R1 soft reset to standby", standby, 1);
        check(gain_sel == 3'd1, "R1 soft reset gain default", gain_sel, 1);
        wr(2'd0, 8'h02, c0);
        wait_vld(3000, t, v);
        check(t == c0 + (S + 32) * D, "R1 default timing after soft reset", t - c0, (S + 32) * D);
        wait_vld(3000, t2, v2);
        check(t2 == t + 32 * D, "R4 default period after soft reset", t2 - t, 32 * D);

        // R3 reserved resolution code behaves as 18-bit
        wr(2'd1, 8'h62, c0);
        wait_vld(3000, t, v);
        check(t == c0 + 32 * D, "R3 reserved code length", t - c0, 32 * D);
        check(v == 64'h3FFFF, "R3 reserved code clip", v, 64'h3FFFF);

        // Random codes
        for (int k = 0; k < 12; k++) begin
            int rs = int'($urandom % 6);
            int rt = int'($urandom % 8);
            int per;
            sample_in = 24'($urandom);
            wr(2'd1, {1'b0, 3'(rs), 1'b0, 3'(rt)}, c0);
            wait_vld(6000, t, v);
            check(t == c0 + f_conv(rs) * D, "R3 random conversion length", t - c0, f_conv(rs) * D);
            check(v == f_clip(longint'(sample_in), rs), "R6 random clip", v, f_clip(longint'(sample_in), rs));
            per = (f_rate(rt) > f_conv(rs)) ? f_rate(rt) : f_conv(rs);
            wait_vld(6000, t2, v2);
            check(t2 == t + per * D, "R4 R5 random period", t2 - t, per * D);
        end

        wr(2'd0, 8'h00, c0);
        idle(600);
        check(standby == 1'b1, "R8 final standby", standby, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule